// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block receives asynchronous serial frames on a single input line. It samples the line sixteen times per bit period, waits for a falling edge and confirms the start bit at its middle. It then shifts in 7 or 8 data bits, least significant first, and an optional parity bit. It samples one stop bit. A free-running divider sets the oversampling rate. When a frame ends, the block decides whether the assembled byte is copied into the holding data register. It also updates four sticky status flags: data-full, overrun, framing error and parity error.

Software talks to the block through a read strobe and a write strobe with a 4-bit write value. A flag is only cleared by writing 0 to it after a read has seen it at 1. The synchronized line level is exposed on its own output. Software can use it to check for a break after a framing error.

Top module: `serial_rx_core`

## Requirements
- R1: After reset the data output is 0x00 and the full, overrun, framing and parity flags all read 0.
- R2: A low pulse on the line that has returned high before the middle of the start bit (8 oversample ticks after the falling edge) starts no frame and changes no output.
- R3: With `cfg_eight`=1 a frame of start bit, 8 data bits sent least significant first, and a high stop bit loads the byte into `rx_data` and sets `flag_full` when `flag_full` was 0.
- R4: With `cfg_eight`=0 only 7 data bits are received, and `rx_data[7]` reads 0.
- R5: `cfg_parity` 2'b01 selects even parity and 2'b10 selects odd parity. Even means the data bits plus the parity bit hold an even number of ones; odd means an odd number. Any mismatch sets `flag_parity`. 2'b00 and 2'b11 mean no parity bit.
- R6: A stop bit sampled low sets `flag_framing`.
- R7: A frame with a framing and/or parity error that completes while `flag_full` is 0 still loads its data into `rx_data`, and `flag_full` stays 0.
- R8: A frame that completes while `flag_full` is 1 leaves `rx_data` unchanged and keeps `flag_full` at 1. It sets `flag_overrun`, plus `flag_framing` or `flag_parity` if that frame has those errors.
- R9: The write value bits are bit0 full, bit1 overrun, bit2 framing, bit3 parity. A `host_rd` pulse marks every flag that reads 1. The next `host_wr` clears exactly the marked flags whose write bit is 0 and unmarks all flags. A write without a prior read, or a write of 1, changes nothing.
- R10: When a flag's set event and its clear write fall in the same cycle, the flag is 1 afterwards.
- R11: While the line is held low (break) the receiver keeps framing. `rx_level` reads 0, and `flag_framing` becomes 1 again after software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Asynchronous serial input line |
| cfg_eight | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_parity | input | 2 | 00/11 none, 01 even, 10 odd |
| host_rd | input | 1 | Status read strobe, marks flags seen at 1 |
| host_wr | input | 1 | Status write strobe |
| host_wdata | input | 4 | Write value {parity, framing, overrun, full} |
| rx_data | output | 8 | Receive data register |
| flag_full | output | 1 | Receive data full flag |
| flag_overrun | output | 1 | Overrun flag |
| flag_framing | output | 1 | Framing error flag |
| flag_parity | output | 1 | Parity error flag |
| rx_level | output | 1 | Synchronized line level |

## Verification
The hardest case to reach from the ports is a clear write landing on exactly the cycle in which a frame raises the same flag. Frame completion happens somewhere inside the stop bit, depending on the divider phase. The bench therefore starts every frame at a fixed divider phase. It first sends a frame with a bad stop bit and counts the cycles until the framing flag appears. It then repeats the identical frame with the flag marked by a read and issues the clear write on that counted cycle. A break is driven with the full flag already set, so every frame the receiver assembles during and after the low period is an overrun, and the final state can be predicted.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    // Parity selection encoding on cfg_parity
    localparam logic [1:0] PAR_EVEN = 2'b01;
    localparam logic [1:0] PAR_ODD  = 2'b10;

    // Framer phases
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } rx_phase_t;

    // Result of one completed frame
    typedef struct packed {
        logic [7:0] data;
        logic       stop_bad;
        logic       par_bad;
    } frame_res_t;

    // Flag bit positions in the status word
    localparam int FL_FULL = 0;
    localparam int FL_OVR  = 1;
    localparam int FL_FRM  = 2;
    localparam int FL_PAR  = 3;
    localparam int FL_N    = 4;
endpackage

// File: rtl/urx_tick_gen.sv
// Oversample tick divider.
// Emits a one-cycle pulse every CLK_DIV clocks. The tick rate is sixteen
// times the bit rate. Assumes CLK_DIV >= 1.
module urx_tick_gen #(
    parameter int CLK_DIV = 27
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (CLK_DIV == 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(CLK_DIV);
            localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
            logic [CW-1:0] cnt;

            // Count clocks, wrapping at the divide value
            always_ff @(posedge clk) begin
                if (!rst_n)          cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                 cnt <= cnt + 1'b1;
            end

            assign tick = (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/urx_framer.sv
// Frame assembler.
// Synchronizes the line and validates the start bit at mid-bit. It then
// shifts in 7 or 8 data bits plus an optional parity bit and samples the
// stop bit. A one-cycle frame_done pulse carries the result.
// Assumes the configuration inputs are stable while a frame is in progress.
module urx_framer
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic       cfg_eight,
    input  logic [1:0] cfg_parity,
    output logic       line_s,
    output logic       frame_done,
    output frame_res_t frame_res
);
    localparam logic [3:0] OS_MID  = 4'd7;
    localparam logic [3:0] OS_LAST = 4'd15;

    logic [1:0] sync_q;
    rx_phase_t  phase;
    logic [3:0] os_cnt;
    logic [2:0] bit_idx;
    logic [7:0] shreg;
    logic       par_bit;
    logic       par_en;
    logic [2:0] last_idx;

    assign line_s   = sync_q[1];
    assign par_en   = (cfg_parity == PAR_EVEN) || (cfg_parity == PAR_ODD);
    assign last_idx = cfg_eight ? 3'd7 : 3'd6;

    // Two-stage synchronizer for the asynchronous line
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    // Frame state machine, advanced on oversample ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            os_cnt     <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            par_bit    <= 1'b0;
            frame_done <= 1'b0;
            frame_res  <= '0;
        end else begin
            frame_done <= 1'b0;
            if (tick) begin
                case (phase)
                    PH_IDLE: begin
                        if (!line_s) begin
                            phase  <= PH_START;
                            os_cnt <= '0;
                        end
                    end
                    PH_START: begin
                        if (os_cnt == OS_MID) begin
                            os_cnt <= '0;
                            if (!line_s) begin
                                phase   <= PH_DATA;
                                bit_idx <= '0;
                                shreg   <= '0;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (os_cnt == OS_LAST) begin
                            os_cnt         <= '0;
                            shreg[bit_idx] <= line_s;
                            if (bit_idx == last_idx) phase <= par_en ? PH_PAR : PH_STOP;
                            else                     bit_idx <= bit_idx + 1'b1;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    PH_PAR: begin
                        if (os_cnt == OS_LAST) begin
                            os_cnt  <= '0;
                            par_bit <= line_s;
                            phase   <= PH_STOP;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    PH_STOP: begin
                        if (os_cnt == OS_LAST) begin
                            os_cnt             <= '0;
                            phase              <= PH_IDLE;
                            frame_done         <= 1'b1;
                            frame_res.data     <= shreg;
                            frame_res.stop_bad <= !line_s;
                            frame_res.par_bad  <= par_en &&
                                ((^shreg ^ par_bit) != (cfg_parity == PAR_ODD));
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    // A completed frame is reported for one cycle only
    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // In 7-bit mode the top data bit of a finished frame is never set
    assert_seven_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !cfg_eight && $stable(cfg_eight)) |-> !frame_res.data[7]);
endmodule

// File: rtl/urx_status.sv
// Receive data register and sticky status flags.
// Decides whether a finished frame is copied into the data register and
// sets the flags for it. Applies the read-then-write-0 clear protocol,
// in which a set event in the same cycle wins over a clear.
module urx_status
    import uart_rx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_done,
    input  frame_res_t      frame_res,
    input  logic            host_rd,
    input  logic            host_wr,
    input  logic [FL_N-1:0] host_wdata,
    output logic [7:0]      data_q,
    output logic [FL_N-1:0] flags_q
);
    logic [FL_N-1:0] armed_q;
    logic [FL_N-1:0] set_v;
    logic [FL_N-1:0] clr_v;
    logic            xfer;
    logic            any_err;

    assign any_err = frame_res.stop_bad | frame_res.par_bad;
    assign xfer    = frame_done & ~flags_q[FL_FULL];

    // Per-flag set events derived from the finished frame
    always_comb begin
        set_v          = '0;
        set_v[FL_FULL] = frame_done & (flags_q[FL_FULL] | ~any_err);
        set_v[FL_OVR]  = frame_done & flags_q[FL_FULL];
        set_v[FL_FRM]  = frame_done & frame_res.stop_bad;
        set_v[FL_PAR]  = frame_done & frame_res.par_bad;
        clr_v          = host_wr ? (armed_q & ~host_wdata) : '0;
    end

    // Sticky flags: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= set_v | (flags_q & ~clr_v);
    end

    // Track which flags a read has seen at 1
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= '0;
        else if (host_wr) armed_q <= '0;
        else if (host_rd) armed_q <= armed_q | flags_q;
    end

    // Copy the frame into the data register unless it overruns
    always_ff @(posedge clk) begin
        if (!rst_n)    data_q <= '0;
        else if (xfer) data_q <= frame_res.data;
    end

    assert_ovr_keeps_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && flags_q[FL_FULL]) |=> $stable(data_q));

    assert_ovr_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && flags_q[FL_FULL]) |=> (flags_q[FL_FULL] && flags_q[FL_OVR]));

    assert_err_no_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !flags_q[FL_FULL] && any_err) |=>
            (!flags_q[FL_FULL] && data_q == $past(frame_res.data)));

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && frame_res.stop_bad) |=> flags_q[FL_FRM]);

    assert_clear_needs_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_done && flags_q[FL_FRM] && !(host_wr && armed_q[FL_FRM])) |=> flags_q[FL_FRM]);
endmodule

// File: rtl/serial_rx_core.sv
// Asynchronous serial receiver top level.
// Ties the oversample divider, the frame assembler and the status register
// together. Assumes rxd idles high.
module serial_rx_core
    import uart_rx_pkg::*;
#(
    parameter int CLK_DIV = 27
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic       cfg_eight,
    input  logic [1:0] cfg_parity,
    input  logic       host_rd,
    input  logic       host_wr,
    input  logic [3:0] host_wdata,
    output logic [7:0] rx_data,
    output logic       flag_full,
    output logic       flag_overrun,
    output logic       flag_framing,
    output logic       flag_parity,
    output logic       rx_level
);
    logic            tick;
    logic            frame_done;
    frame_res_t      frame_res;
    logic [FL_N-1:0] flags;

    urx_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    urx_framer u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .rxd        (rxd),
        .cfg_eight  (cfg_eight),
        .cfg_parity (cfg_parity),
        .line_s     (rx_level),
        .frame_done (frame_done),
        .frame_res  (frame_res)
    );

    urx_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_res  (frame_res),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .data_q     (rx_data),
        .flags_q    (flags)
    );

    assign flag_full    = flags[FL_FULL];
    assign flag_overrun = flags[FL_OVR];
    assign flag_framing = flags[FL_FRM];
    assign flag_parity  = flags[FL_PAR];
endmodule

// File: tb/serial_rx_core_test.sv
module serial_rx_core_test;
    localparam int DIV = 4;
    localparam int BITCYC = 16 * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1;
    logic cfg_eight = 1'b1;
    logic [1:0] cfg_parity = 2'b00;
    logic host_rd = 1'b0;
    logic host_wr = 1'b0;
    logic [3:0] host_wdata = 4'hF;
    logic [7:0] rx_data;
    logic flag_full, flag_overrun, flag_framing, flag_parity, rx_level;

    serial_rx_core #(.CLK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .cfg_eight(cfg_eight),
        .cfg_parity(cfg_parity), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .rx_data(rx_data), .flag_full(flag_full),
        .flag_overrun(flag_overrun), .flag_framing(flag_framing),
        .flag_parity(flag_parity), .rx_level(rx_level)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit busy = 1'b1;
    bit done_flag = 1'b0;

    // Reference model: flags {parity, framing, overrun, full}
    logic [7:0] m_data = 8'h00;
    logic [3:0] m_flags = 4'h0;
    logic [3:0] m_arm = 4'h0;

    // Frame-drive controls
    int g_measure = 0;
    int g_lat = -1;
    int g_clr_at = -1;
    int g_chk_at = -1;
    logic [3:0] g_clr_val = 4'hF;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Compare against the model on every idle clock
    always @(negedge clk) begin
        if (!busy && !done_flag) begin
            chk("R3 data", rx_data, m_data);
            chk("R3 full", flag_full, m_flags[0]);
            chk("R8 overrun", flag_overrun, m_flags[1]);
            chk("R6 framing", flag_framing, m_flags[2]);
            chk("R5 parity", flag_parity, m_flags[3]);
        end
    end

    task automatic host_read();
        @(negedge clk) host_rd = 1'b1;
        @(posedge clk) m_arm = m_arm | m_flags;
        @(negedge clk) host_rd = 1'b0;
    endtask

    task automatic host_write(input logic [3:0] v);
        @(negedge clk) begin host_wr = 1'b1; host_wdata = v; end
        @(posedge clk) begin m_flags = m_flags & ~(m_arm & ~v); m_arm = 4'h0; end
        @(negedge clk) host_wr = 1'b0;
    endtask

    task automatic model_frame(input logic [7:0] d, input bit fe, input bit pe);
        if (m_flags[0]) m_flags[1] = 1'b1;
        else begin
            m_data = d;
            if (!fe && !pe) m_flags[0] = 1'b1;
        end
        if (fe) m_flags[2] = 1'b1;
        if (pe) m_flags[3] = 1'b1;
    endtask

    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit stop_val);
        logic bits [0:11];
        int n;
        int nb;
        bit par_on;
        logic [7:0] dm;
        nb = cfg_eight ? 8 : 7;
        dm = cfg_eight ? d : (d & 8'h7F);
        par_on = (cfg_parity == 2'b01) || (cfg_parity == 2'b10);
        n = 0;
        bits[n] = 1'b0; n++;
        for (int i = 0; i < nb; i++) begin bits[n] = dm[i]; n++; end
        if (par_on) begin
            bits[n] = (^dm) ^ (cfg_parity == 2'b10) ^ bad_par; n++;
        end
        bits[n] = stop_val; n++;
        // start at a fixed divider phase
        do @(negedge clk); while (cyc % DIV != 0);
        busy = 1'b1;
        for (int k = 0; k < n * BITCYC; k++) begin
            if (k != 0) @(negedge clk);
            if (g_measure != 0 && g_lat < 0 && flag_framing) g_lat = k;
            if (k == g_chk_at) chk("R10 set beats clear", flag_framing, 1);
            if (k == g_clr_at) begin host_wr = 1'b1; host_wdata = g_clr_val; end
            else if (k == g_clr_at + 1) host_wr = 1'b0;
            rxd = bits[k / BITCYC];
        end
        @(negedge clk) rxd = 1'b1;
        model_frame(dm, !stop_val, par_on && bad_par);
        busy = 1'b0;
        repeat (BITCYC) @(negedge clk);
    endtask

    task automatic clear_all();
        host_read();
        host_write(4'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 data", rx_data, 0);
        chk("R1 flags", {flag_parity, flag_framing, flag_overrun, flag_full}, 0);
        busy = 1'b0;
        repeat (10) @(negedge clk);

        // R2 short glitch ignored
        rxd = 1'b0;
        repeat (3 * DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BITCYC) @(negedge clk);
        chk("R2 glitch no full", flag_full, 0);
        chk("R2 glitch no framing", flag_framing, 0);

        // R3 8N1 clean frame
        cfg_eight = 1'b1; cfg_parity = 2'b00;
        send_frame(8'hA5, 0, 1);
        chk("R3 byte", rx_data, 8'hA5);
        chk("R3 full set", flag_full, 1);

        // R9 clear protocol
        host_write(4'h0);
        chk("R9 write without read", flag_full, 1);
        host_read();
        host_write(4'hF);
        chk("R9 write of 1", flag_full, 1);
        host_read();
        host_write(4'hE);
        chk("R9 cleared after read", flag_full, 0);

        // R4 7-bit even parity
        cfg_eight = 1'b0; cfg_parity = 2'b01;
        send_frame(8'hD5, 0, 1);
        chk("R4 seven bit data", rx_data, 8'h55);
        chk("R5 even ok", flag_parity, 0);
        clear_all();

        // R5 odd parity good, then even parity bad
        cfg_eight = 1'b1; cfg_parity = 2'b10;
        send_frame(8'h01, 0, 1);
        chk("R5 odd ok", flag_parity, 0);
        clear_all();
        cfg_parity = 2'b01;
        send_frame(8'h3C, 1, 1);
        chk("R5 parity error", flag_parity, 1);
        chk("R7 data moved", rx_data, 8'h3C);
        chk("R7 full stays 0", flag_full, 0);
        clear_all();

        // R6 framing error, no parity
        cfg_parity = 2'b00;
        send_frame(8'h96, 0, 0);
        chk("R6 framing set", flag_framing, 1);
        chk("R7 fe data moved", rx_data, 8'h96);
        clear_all();

        // R8 overrun, then overrun with framing error
        send_frame(8'h11, 0, 1);
        send_frame(8'h99, 0, 1);
        chk("R8 data kept", rx_data, 8'h11);
        chk("R8 overrun set", flag_overrun, 1);
        send_frame(8'h77, 0, 0);
        chk("R8 data kept fe", rx_data, 8'h11);
        chk("R8 fe with overrun", flag_framing, 1);
        chk("R8 full kept", flag_full, 1);
        clear_all();

        // R10 measure completion latency, then clear on that cycle
        g_measure = 1;
        send_frame(8'h42, 0, 0);
        g_measure = 0;
        chk("R10 latency found", (g_lat > 0) ? 1 : 0, 1);
        host_read();
        g_clr_at = g_lat - 1; g_chk_at = g_lat; g_clr_val = 4'hB;
        send_frame(8'h42, 0, 0);
        m_arm = 4'h0;
        g_clr_at = -1; g_chk_at = -1;
        clear_all();

        // R11 break with full already set
        send_frame(8'h5A, 0, 1);
        busy = 1'b1;
        @(negedge clk) rxd = 1'b0;
        repeat (12 * BITCYC) @(negedge clk);
        chk("R11 line level low", rx_level, 0);
        chk("R11 framing during break", flag_framing, 1);
        host_rd = 1'b1; @(negedge clk) host_rd = 1'b0;
        host_wr = 1'b1; host_wdata = 4'hB; @(negedge clk) host_wr = 1'b0;
        chk("R11 framing cleared", flag_framing, 0);
        repeat (20 * BITCYC) @(negedge clk);
        rxd = 1'b1;
        repeat (12 * BITCYC) @(negedge clk);
        chk("R11 line level high", rx_level, 1);
        chk("R11 framing set again", flag_framing, 1);
        m_flags[1] = 1'b1; m_flags[2] = 1'b1; m_arm = 4'h0;
        busy = 1'b0;
        repeat (20) @(negedge clk);
        chk("R11 data kept", rx_data, 8'h5A);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule